// File: doc/BRIEF.md
# Multi-Tap Circular Sample Delay Line

This block keeps a history of audio samples in on-chip RAM organised as a ring. One producer writes samples through a valid/ready stream. Each write lands at the slot named by a write pointer, which then advances and wraps at the end of the buffer. Any number of read taps fetch samples from this history. A tap is given a delay count, meaning how many samples back from the newest one to read, and it answers with exactly one sample on its own output stream.

The RAM has one port, and every access goes through it. An arbiter gives the port to the write stream first. Reads from the taps take the cycles the write leaves free, and the taps are served in rotating order. Because a tap can be asked for several delays between two writes, it can fetch neighbouring samples for interpolation.

A build-time option turns on fixed-delay mode. In this mode every tap fires on each write with its own constant delay, and the external tap requests are ignored. Chorus, echo and comb structures can then be built from the block without extra control logic.

Top module: `dly_line`

## Requirements
- R1: After a synchronous active-high reset, wr_ready is 1, every req_ready bit is 1 and every resp_valid bit is 0.
- R2: The write pointer starts at 0, advances by one slot per accepted write and wraps modulo DEPTH. A request with delay 0 returns the newest sample, both before and after the pointer has wrapped.
- R3: A request with delay d returns the sample written d writes before the newest one. This includes d = DEPTH-1 once the buffer has wrapped.
- R4: A request whose delay reaches past the number of samples written since reset returns 0.
- R5: With no contention, resp_valid of a tap rises after the second rising clock edge that follows the edge on which its request was accepted.
- R6: Each accepted request gives exactly one response. A tap's req_ready stays low from acceptance until its response has been taken. resp_valid and resp_data hold steady while resp_ready is low.
- R7: In request mode wr_ready is always 1, and a write wins the memory port. A write in the cycle a read would be granted delays that read by one cycle. The delay count is measured from the newest sample at the moment the request is accepted.
- R8: Taps that are waiting are granted one per free cycle, in rotating order starting after the most recently granted tap. After reset, tap 0 comes first.
- R9: A write accepted in the same cycle as a request counts as the newest sample for that request.
- R10: In fixed-delay mode every accepted write starts one read on every tap with that tap's constant delay. The external req_valid and req_delay inputs have no effect. wr_ready is 0 while any tap still has a response pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write sample valid |
| wr_ready | output | 1 | Write sample accepted |
| wr_data | input | SW | Sample to store (signed) |
| req_valid | input | NTAPS | Per-tap delay request valid |
| req_ready | output | NTAPS | Per-tap request accepted (tap idle) |
| req_delay | input | NTAPS*log2(DEPTH) | Per-tap delay count, tap i in slice i |
| resp_valid | output | NTAPS | Per-tap response valid |
| resp_ready | input | NTAPS | Per-tap response taken |
| resp_data | output | NTAPS*SW | Per-tap returned sample, tap i in slice i |

## Verification
When the port is free, a tap's response appears two edges after its request is accepted. Each write that collides with the grant cycle adds one edge, and each tap granted ahead of it in the rotation adds one edge. The bench counts edges from the acceptance edge and samples the outputs on the falling edge. It checks the exact cycle in which resp_valid rises, and in rotation tests it checks the bitmap of all tap valids edge by edge, so an ordering error or an extra register stage is caught. In fixed-delay mode the bench counts from the write edge: one edge to the first grant, then one more edge per tap.

// File: rtl/dly_pkg.sv
package dly_pkg;
  typedef enum logic [1:0] {
    TAP_IDLE = 2'd0,
    TAP_WAIT = 2'd1,
    TAP_INFL = 2'd2,
    TAP_HOLD = 2'd3
  } tap_state_e;
endpackage

// File: rtl/dly_wptr.sv
module dly_wptr #(
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_fire,
  output logic [AW-1:0] ptr,
  output logic [AW-1:0] ptr_nxt,
  output logic          full_nxt
);
  logic full_q;

  always_comb begin
    ptr_nxt  = wr_fire ? ptr + AW'(1) : ptr;
    full_nxt = full_q | (wr_fire && (ptr == AW'(DEPTH - 1)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr    <= '0;
      full_q <= 1'b0;
    end else begin
      ptr    <= ptr_nxt;
      full_q <= full_nxt;
    end
  end
endmodule

// File: rtl/dly_spram.sv
module dly_spram #(
  parameter int DEPTH = 512,
  parameter int SW    = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [SW-1:0] wdata,
  output logic [SW-1:0] q
);
  logic [SW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    else    q         <= mem[addr];
  end
endmodule

// File: rtl/dly_rr_arb.sv
module dly_rr_arb #(
  parameter int N = 3,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         block,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  logic [IW-1:0] last;
  logic          hit;

  // search starts one place after the last winner
  always_comb begin
    gnt = '0;
    hit = 1'b0;
    if (!block) begin
      for (int k = 1; k <= N; k++) begin
        for (int j = 0; j < N; j++) begin
          if (!hit && req[j] && (((int'(last) + k) % N) == j)) begin
            gnt[j] = 1'b1;
            hit    = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last <= IW'(N - 1);
    end else begin
      for (int j = 0; j < N; j++) begin
        if (gnt[j]) last <= IW'(j);
      end
    end
  end
endmodule

// File: rtl/dly_tap.sv
module dly_tap
  import dly_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int SW    = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [AW-1:0] dly,
  input  logic [AW-1:0] base_ptr,
  input  logic          base_full,
  output logic          idle,
  output logic          rd_req,
  input  logic          rd_gnt,
  output logic [AW-1:0] rd_addr,
  input  logic [SW-1:0] ram_q,
  output logic          resp_valid,
  input  logic          resp_ready,
  output logic [SW-1:0] resp_data
);
  tap_state_e state;
  logic       blank;

  assign idle       = (state == TAP_IDLE);
  assign rd_req     = (state == TAP_WAIT);
  assign resp_valid = (state == TAP_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= TAP_IDLE;
      rd_addr   <= '0;
      blank     <= 1'b0;
      resp_data <= '0;
    end else begin
      unique case (state)
        TAP_IDLE: if (go) begin
          rd_addr <= base_ptr - AW'(1) - dly;
          blank   <= !base_full && (dly >= base_ptr);
          state   <= TAP_WAIT;
        end
        TAP_WAIT: if (rd_gnt) state <= TAP_INFL;
        TAP_INFL: begin
          resp_data <= blank ? '0 : ram_q;
          state     <= TAP_HOLD;
        end
        TAP_HOLD: if (resp_ready) state <= TAP_IDLE;
        default:  state <= TAP_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dly_line.sv
module dly_line #(
  parameter int DEPTH = 512,
  parameter int NTAPS = 3,
  parameter int SW    = 16,
  parameter int FIXED = 0,
  parameter logic [NTAPS*32-1:0] FIXED_DLY = {NTAPS{32'd0}},
  localparam int AW = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_valid,
  output logic                wr_ready,
  input  logic [SW-1:0]       wr_data,
  input  logic [NTAPS-1:0]    req_valid,
  output logic [NTAPS-1:0]    req_ready,
  input  logic [NTAPS*AW-1:0] req_delay,
  output logic [NTAPS-1:0]    resp_valid,
  input  logic [NTAPS-1:0]    resp_ready,
  output logic [NTAPS*SW-1:0] resp_data
);
  logic             wr_fire;
  logic [AW-1:0]    wptr, wptr_nxt;
  logic             full_nxt;
  logic [NTAPS-1:0] tap_go, tap_idle, rd_req, gnt;
  logic [AW-1:0]    tap_dly  [NTAPS];
  logic [AW-1:0]    tap_addr [NTAPS];
  logic [AW-1:0]    rd_addr, ram_addr;
  logic [SW-1:0]    ram_q;

  generate
    if (FIXED != 0) begin : g_fixed
      assign wr_ready = &tap_idle;
      for (genvar i = 0; i < NTAPS; i++) begin : g_src
        assign tap_go[i]  = wr_fire;
        assign tap_dly[i] = AW'(FIXED_DLY[i*32 +: 32]);
      end
      logic unused_req;
      assign unused_req = ^{req_valid, req_delay};
    end else begin : g_req
      assign wr_ready = 1'b1;
      for (genvar i = 0; i < NTAPS; i++) begin : g_src
        assign tap_go[i]  = req_valid[i];
        assign tap_dly[i] = req_delay[i*AW +: AW];
      end
    end
  endgenerate

  assign wr_fire   = wr_valid & wr_ready;
  assign req_ready = tap_idle;

  dly_wptr #(.DEPTH(DEPTH)) u_wptr (
    .clk(clk), .rst(rst), .wr_fire(wr_fire),
    .ptr(wptr), .ptr_nxt(wptr_nxt), .full_nxt(full_nxt)
  );

  dly_rr_arb #(.N(NTAPS)) u_arb (
    .clk(clk), .rst(rst), .block(wr_fire), .req(rd_req), .gnt(gnt)
  );

  always_comb begin
    rd_addr = '0;
    for (int i = 0; i < NTAPS; i++) begin
      if (gnt[i]) rd_addr = rd_addr | tap_addr[i];
    end
  end

  assign ram_addr = wr_fire ? wptr : rd_addr;

  dly_spram #(.DEPTH(DEPTH), .SW(SW)) u_ram (
    .clk(clk), .we(wr_fire), .addr(ram_addr), .wdata(wr_data), .q(ram_q)
  );

  generate
    for (genvar i = 0; i < NTAPS; i++) begin : g_tap
      dly_tap #(.DEPTH(DEPTH), .SW(SW)) u_tap (
        .clk(clk), .rst(rst),
        .go(tap_go[i]), .dly(tap_dly[i]),
        .base_ptr(wptr_nxt), .base_full(full_nxt),
        .idle(tap_idle[i]), .rd_req(rd_req[i]), .rd_gnt(gnt[i]),
        .rd_addr(tap_addr[i]), .ram_q(ram_q),
        .resp_valid(resp_valid[i]), .resp_ready(resp_ready[i]),
        .resp_data(resp_data[i*SW +: SW])
      );
    end
  endgenerate
endmodule

// File: rtl/dly_chk.sv
module dly_chk #(
  parameter int NTAPS = 3,
  parameter int SW    = 16,
  parameter int FIXED = 0
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_ready,
  input logic                wr_fire,
  input logic [NTAPS-1:0]    grant,
  input logic [NTAPS-1:0]    req_ready,
  input logic [NTAPS-1:0]    resp_valid,
  input logic [NTAPS-1:0]    resp_ready,
  input logic [NTAPS*SW-1:0] resp_data
);
  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (resp_valid == '0) && (req_ready == {NTAPS{1'b1}}));

  p_wr_prio_r7: assert property (@(posedge clk) disable iff (rst)
    wr_fire |-> (grant == '0));

  p_one_grant_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  generate
    for (genvar i = 0; i < NTAPS; i++) begin : g_tap
      p_busy_r6: assert property (@(posedge clk) disable iff (rst)
        resp_valid[i] |-> !req_ready[i]);
      p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        resp_valid[i] && !resp_ready[i] |=>
          resp_valid[i] && $stable(resp_data[i*SW +: SW]));
    end
    if (FIXED != 0) begin : g_fx
      p_all_fire_r10: assert property (@(posedge clk) disable iff (rst)
        wr_fire |=> (req_ready == '0));
    end else begin : g_rq
      p_wr_open_r7: assert property (@(posedge clk) disable iff (rst)
        wr_ready);
    end
  endgenerate
endmodule

bind dly_line dly_chk #(.NTAPS(NTAPS), .SW(SW), .FIXED(FIXED)) u_chk (
  .clk(clk), .rst(rst), .wr_ready(wr_ready), .wr_fire(wr_fire),
  .grant(gnt), .req_ready(req_ready), .resp_valid(resp_valid),
  .resp_ready(resp_ready), .resp_data(resp_data)
);

// File: tb/tb_dly_line.sv
`timescale 1ns/1ps
module tb_dly_line;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  // request-mode instance: depth 16, three taps
  logic        wr_valid = 0, wr_ready;
  logic [15:0] wr_data = 0;
  logic [2:0]  req_valid = 0, req_ready, resp_valid, resp_ready = 0;
  logic [11:0] req_delay = 0;
  logic [47:0] resp_data;

  dly_line #(.DEPTH(16), .NTAPS(3), .SW(16), .FIXED(0)) dut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .req_valid(req_valid), .req_ready(req_ready),
    .req_delay(req_delay), .resp_valid(resp_valid),
    .resp_ready(resp_ready), .resp_data(resp_data));

  // fixed-delay instance: tap0 delay 0, tap1 delay 2
  logic        fx_wr_valid = 0, fx_wr_ready;
  logic [15:0] fx_wr_data = 0;
  logic [1:0]  fx_req_valid = 2'b11, fx_req_ready, fx_resp_valid, fx_resp_ready = 0;
  logic [7:0]  fx_req_delay = 8'hFF;
  logic [31:0] fx_resp_data;

  dly_line #(.DEPTH(16), .NTAPS(2), .SW(16), .FIXED(1),
             .FIXED_DLY({32'd2, 32'd0})) dut_fx (
    .clk(clk), .rst(rst), .wr_valid(fx_wr_valid), .wr_ready(fx_wr_ready),
    .wr_data(fx_wr_data), .req_valid(fx_req_valid), .req_ready(fx_req_ready),
    .req_delay(fx_req_delay), .resp_valid(fx_resp_valid),
    .resp_ready(fx_resp_ready), .resp_data(fx_resp_data));

  int nchk = 0, nfail = 0;
  logic [15:0] hist [64];
  int cnt = 0;

  // {tap[21:20], delay[19:16], expected[15:0]} after writing 11,22,33,44,55
  localparam logic [21:0] VEC [6] = '{
    {2'd0, 4'd0,  16'd55},
    {2'd1, 4'd1,  16'd44},
    {2'd2, 4'd4,  16'd11},
    {2'd0, 4'd5,  16'd0},
    {2'd1, 4'd15, 16'd0},
    {2'd2, 4'd2,  16'd33}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [15:0] v);
    hist[cnt] = v;
    cnt++;
  endtask

  function automatic logic [15:0] model(input int d);
    return (d < cnt) ? hist[cnt-1-d] : 16'd0;
  endfunction

  task automatic wr(input logic [15:0] v);
    wr_valid = 1; wr_data = v;
    @(posedge clk); @(negedge clk);
    wr_valid = 0;
    push(v);
  endtask

  // wmode 0: none, 1: write in accept cycle, 2: write in following cycle
  task automatic rd(input int tap, input int d, input int wmode, input logic [15:0] wval,
                    input int exp_lat, input logic [15:0] exp_d, input string rq);
    int n;
    logic [15:0] held;
    req_valid[tap] = 1; req_delay[tap*4 +: 4] = 4'(d);
    if (wmode == 1) begin wr_valid = 1; wr_data = wval; end
    @(posedge clk); @(negedge clk);
    req_valid[tap] = 0;
    if (wmode == 1) begin wr_valid = 0; push(wval); end
    chk({rq, " R6 busy after accept"}, 32'(req_ready[tap]), 0);
    if (wmode == 2) begin
      chk("R7 wr_ready high", 32'(wr_ready), 1);
      wr_valid = 1; wr_data = wval;
    end
    n = 0;
    while (n < 8) begin
      @(posedge clk); @(negedge clk);
      n++;
      if (wmode == 2 && n == 1) begin wr_valid = 0; push(wval); end
      if (resp_valid[tap]) break;
    end
    chk({rq, " latency"}, 32'(n), 32'(exp_lat));
    chk({rq, " data"}, 32'(resp_data[tap*16 +: 16]), 32'(exp_d));
    held = resp_data[tap*16 +: 16];
    @(posedge clk); @(negedge clk);
    chk("R6 hold valid", 32'(resp_valid[tap]), 1);
    chk("R6 hold data", 32'(resp_data[tap*16 +: 16]), 32'(held));
    resp_ready[tap] = 1;
    @(posedge clk); @(negedge clk);
    resp_ready[tap] = 0;
    chk("R6 single response", 32'(resp_valid[tap]), 0);
    chk("R6 ready again", 32'(req_ready[tap]), 1);
  endtask

  task automatic finish_up;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_up();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1
    chk("R1 wr_ready", 32'(wr_ready), 1);
    chk("R1 req_ready", 32'(req_ready), 32'h7);
    chk("R1 resp_valid", 32'(resp_valid), 0);
    chk("R1 fx wr_ready", 32'(fx_wr_ready), 1);

    // R4 and R5: nothing written yet
    rd(0, 3, 0, 0, 2, 16'd0, "R4 R5 empty buffer");

    wr(16'd11); wr(16'd22); wr(16'd33); wr(16'd44); wr(16'd55);
    for (int k = 0; k < 6; k++) begin
      rd(int'(VEC[k][21:20]), int'(VEC[k][19:16]), 0, 0, 2, VEC[k][15:0],
         (k == 0) ? "R2 table" : ((VEC[k][15:0] == 0) ? "R4 table" : "R3 table"));
    end

    // wrap the pointer
    for (int k = 0; k < 20; k++) wr(16'(k * 1237 - 9000));
    rd(1, 0, 0, 0, 2, model(0), "R2 after wrap");
    rd(2, 15, 0, 0, 2, model(15), "R3 oldest after wrap");

    // R7: write collides with grant cycle, delay measured at acceptance
    begin
      logic [15:0] e;
      e = model(0);
      rd(0, 0, 2, 16'h1234, 3, e, "R7 write priority");
    end
    chk("R7 pushed sample", 32'(model(0)), 32'h1234);
    rd(2, 0, 0, 0, 2, 16'h1234, "R7 write landed");

    // R9: write and request in the same cycle
    rd(1, 0, 1, 16'h7A5C, 2, 16'h7A5C, "R9 same-cycle write");
    rd(1, 1, 0, 0, 2, 16'h1234, "R9 older neighbour");

    // R8: tap0 alone, then tap0 and tap1 together -> tap1 wins first
    rd(0, 2, 0, 0, 2, model(2), "R8 prime");
    req_valid = 3'b011; req_delay = {4'd0, 4'd1, 4'd0};
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    @(posedge clk); @(negedge clk);
    chk("R8 pair edge1", 32'(resp_valid), 0);
    @(posedge clk); @(negedge clk);
    chk("R8 pair edge2", 32'(resp_valid), 32'b010);
    @(posedge clk); @(negedge clk);
    chk("R8 pair edge3", 32'(resp_valid), 32'b011);
    chk("R8 tap0 data", 32'(resp_data[15:0]), 32'(model(0)));
    chk("R8 tap1 data", 32'(resp_data[31:16]), 32'(model(1)));
    resp_ready = 3'b111;
    @(posedge clk); @(negedge clk);
    resp_ready = 0;

    // R8: all three, last grant was tap0 -> order 1, 2, 0
    req_valid = 3'b111; req_delay = {4'd2, 4'd1, 4'd0};
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    chk("R8 trio edge2", 32'(resp_valid), 32'b010);
    @(posedge clk); @(negedge clk);
    chk("R8 trio edge3", 32'(resp_valid), 32'b110);
    @(posedge clk); @(negedge clk);
    chk("R8 trio edge4", 32'(resp_valid), 32'b111);
    chk("R8 trio tap2 data", 32'(resp_data[47:32]), 32'(model(2)));
    resp_ready = 3'b111;
    @(posedge clk); @(negedge clk);
    resp_ready = 0;
    chk("R6 trio drained", 32'(resp_valid), 0);

    // R10: fixed-delay instance
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R10 requests ignored", 32'(fx_resp_valid), 0);
    for (int k = 0; k < 3; k++) begin
      logic [15:0] v, e1;
      v  = (k == 0) ? 16'd5 : ((k == 1) ? 16'hFFFA : 16'd7);
      e1 = (k == 2) ? 16'd5 : 16'd0;
      fx_wr_valid = 1; fx_wr_data = v;
      @(posedge clk); @(negedge clk);
      fx_wr_valid = 0;
      chk("R10 wr_ready low while pending", 32'(fx_wr_ready), 0);
      @(posedge clk); @(negedge clk);
      chk("R10 edge1", 32'(fx_resp_valid), 0);
      @(posedge clk); @(negedge clk);
      chk("R10 edge2", 32'(fx_resp_valid), 32'b01);
      @(posedge clk); @(negedge clk);
      chk("R10 edge3", 32'(fx_resp_valid), 32'b11);
      chk("R10 tap0 data", 32'(fx_resp_data[15:0]), 32'(v));
      chk("R10 tap1 data", 32'(fx_resp_data[31:16]), 32'(e1));
      fx_resp_ready = 2'b11;
      @(posedge clk); @(negedge clk);
      fx_resp_ready = 0;
      chk("R10 one sample per write", 32'(fx_resp_valid), 0);
      chk("R10 wr_ready restored", 32'(fx_wr_ready), 1);
    end

    finish_up();
  end
endmodule